// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Access Controller

This block is a clocked controller that turns single-word requests from a host into correctly timed cycles on an asynchronous pseudo-static RAM of 1M words by 16 bits. The host side is a valid/ready request port. Each request carries a word address, a write flag, write data and a two-bit byte mask. Read data comes back with a one-cycle valid strobe. On the memory side the block drives an active-low and an active-high chip enable, output enable, write enable, two active-low byte-lane enables, the address bus and a tri-stated 16-bit data bus.

Every analog timing figure is a nanosecond parameter. Each one is turned into a cycle count by rounding up against the clock-period parameter. After reset the controller holds the memory deselected through the power-up wait, and it accepts no request during that time. Every access is framed the same way. The address settles first with the chip still deselected, so every read is controlled by chip enable. The chip is then selected for a bounded number of cycles. A deselected recovery period follows, and it also covers the output turn-off time after a read.

The states are ST_PWRUP (power-up lockout), ST_IDLE (ready for a request), ST_SETUP (address driven, chip deselected), ST_READ (selected, output enable low), ST_WRITE (selected, write enable low, bus driven), ST_WHOLD (deselected, bus still driven) and ST_RECOV (deselected recovery). The transitions are:
- ST_PWRUP to ST_IDLE when the power-up count completes.
- ST_IDLE to ST_SETUP on an accepted request with a non-zero mask.
- ST_IDLE back to ST_IDLE on an accepted request with a zero mask.
- ST_SETUP to ST_READ or ST_WRITE, according to the write flag.
- ST_READ to ST_RECOV when the read timer expires.
- ST_WRITE to ST_WHOLD when the write timer expires.
- ST_WHOLD to ST_RECOV after one cycle.
- ST_RECOV to ST_IDLE when the recovery timer expires.

Top module: `psram_ctl`

## Requirements
- R1: The memory counts as selected only when mem_ce1_n is 0 and mem_ce2 is 1. Whenever the controller is not in ST_READ or ST_WRITE, it drives mem_ce1_n=1 and mem_ce2=0.
- R2: Mask bit 0 set to 1 drives mem_lane_n[0] low, which gates data bits 7:0. Mask bit 1 set to 1 drives mem_lane_n[1] low, which gates bits 15:8. While deselected, both lanes are high. Read data bits in a lane whose mask bit is 0 return as zero.
- R3: During a read the chip is selected with mem_oe_n=0 and mem_we_n=1. During a write the chip is selected with mem_we_n=0 and mem_oe_n=1, and the write data is on mem_dq. The data stays driven for one more deselected hold cycle with mem_we_n=1.
- R4: After reset, req_ready is 0 and the chip is deselected for ceil(T_PU_NS/CLK_PERIOD_NS) cycles. The first cycle with req_ready=1 follows the edge numbered that count plus one.
- R5: A read keeps the chip selected for ceil(max(T_RC_NS, T_ACE_NS, T_DOE_NS)/CLK_PERIOD_NS) cycles. The data is captured at the end of the last selected cycle. rsp_valid is 1 for exactly the following cycle, carrying that data.
- R6: Between two selected periods, the chip stays deselected for at least ceil(T_CD_NS/CLK_PERIOD_NS) cycles.
- R7: The address of the request is on mem_addr one full cycle before the chip is selected, and it stays unchanged for the whole selected period.
- R8: No selected period reaches ceil(T_MAXSEL_NS/CLK_PERIOD_NS) cycles.
- R9: After mem_oe_n rises, at least ceil(T_HZOE_NS/CLK_PERIOD_NS) cycles pass before mem_we_n falls and the controller drives the bus.
- R10: A request with mask 0 is accepted, selects nothing and changes no memory content. If it is a read, rsp_valid is 1 in the next cycle with data 0.
- R11: req_ready is 1 only in ST_IDLE, and a request is taken when req_valid and req_ready are both 1. After acceptance the order is: one setup cycle, then the selected cycles, then recovery. A write is selected for ceil(T_WC_NS/CLK_PERIOD_NS) cycles, followed by one hold cycle and ceil(T_CD_NS/CLK_PERIOD_NS) recovery cycles. A read is followed by max(ceil(T_CD_NS), ceil(T_HZOE_NS)) recovery cycles, with both values converted to cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 16 | Read data |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_lane_n | output | 2 | Active-low byte-lane enables |
| mem_addr | output | 20 | Memory word address |
| mem_dq | inout | 16 | Tri-stated memory data bus |

## Verification
With the 8 ns clock and defaults, a read accepted at edge k has its setup cycle right after k and nine selected cycles after that. rsp_valid is due in the cycle following edge k+10, and req_ready returns four cycles later. An accepted write is selected in the cycles after edges k+1 through k+9, holds the bus for one more cycle and recovers for two. The reference model turns every accepted request into a queue of per-cycle expectations that follow this count. It compares the pins, handshake and response against the queue at each falling edge, so every result is sampled in the exact cycle it is due. Deselect gaps, selected-run lengths and the output-enable-to-write-enable gap are measured separately from the pins.

// File: rtl/psram_ctl_pkg.sv
package psram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_SETUP,
        ST_READ,
        ST_WRITE,
        ST_WHOLD,
        ST_RECOV
    } psram_state_e;

    // Round a nanosecond figure up to whole clock periods, never below one.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_pwrup_gate.sv
module psram_pwrup_gate #(
    parameter int CYCLES = 25000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int W = $clog2(CYCLES + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            done  <= 1'b0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
            done  <= (cnt_q == W'(CYCLES - 1));
        end
    end
endmodule

// File: rtl/psram_phase_timer.sv
module psram_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/psram_ctl.sv
module psram_ctl
    import psram_ctl_pkg::*;
#(
    parameter int ADDR_W        = 20,
    parameter int DATA_W        = 16,
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_PU_NS       = 200000,
    parameter int T_RC_NS       = 70,
    parameter int T_ACE_NS      = 70,
    parameter int T_DOE_NS      = 35,
    parameter int T_WC_NS       = 70,
    parameter int T_CD_NS       = 15,
    parameter int T_HZOE_NS     = 25,
    parameter int T_MAXSEL_NS   = 40000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_be,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  mem_ce1_n,
    output logic                  mem_ce2,
    output logic                  mem_oe_n,
    output logic                  mem_we_n,
    output logic [DATA_W/8-1:0]   mem_lane_n,
    output logic [ADDR_W-1:0]     mem_addr,
    inout  wire  [DATA_W-1:0]     mem_dq
);
    localparam int LANES      = DATA_W / 8;
    localparam int PU_CYC     = ns_to_cyc(T_PU_NS, CLK_PERIOD_NS);
    localparam int RD_CYC     = imax(imax(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS),
                                          ns_to_cyc(T_ACE_NS, CLK_PERIOD_NS)),
                                     ns_to_cyc(T_DOE_NS, CLK_PERIOD_NS));
    localparam int WR_CYC     = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
    localparam int CD_CYC     = ns_to_cyc(T_CD_NS, CLK_PERIOD_NS);
    localparam int HZOE_CYC   = ns_to_cyc(T_HZOE_NS, CLK_PERIOD_NS);
    localparam int REC_RD     = imax(CD_CYC, HZOE_CYC);
    localparam int REC_WR     = CD_CYC;
    localparam int MAXSEL_CYC = ns_to_cyc(T_MAXSEL_NS, CLK_PERIOD_NS);
    localparam int TW         = $clog2(imax(imax(RD_CYC, WR_CYC), REC_RD) + 1);
    localparam logic [TW-1:0] RD_LOAD  = TW'(RD_CYC - 1);
    localparam logic [TW-1:0] WR_LOAD  = TW'(WR_CYC - 1);
    localparam logic [TW-1:0] RRD_LOAD = TW'(REC_RD - 1);
    localparam logic [TW-1:0] RWR_LOAD = TW'(REC_WR - 1);

    psram_state_e state_q, state_d;

    logic                 pu_done;
    logic                 tmr_load;
    logic [TW-1:0]        tmr_val;
    logic                 tmr_expired;
    logic                 accept;
    logic                 wr_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [DATA_W-1:0]    wdata_q;
    logic [LANES-1:0]     be_q;
    logic [DATA_W-1:0]    lane_mask;
    logic                 sel;
    logic                 dq_oe;

    psram_pwrup_gate #(.CYCLES(PU_CYC)) u_pwrup (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (pu_done)
    );

    psram_phase_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g*8 +: 8] = {8{be_q[g]}};
    end

    assign accept = (state_q == ST_IDLE) && req_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PWRUP;
        else        state_q <= state_d;
    end

    // Next state and timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_PWRUP: if (pu_done) state_d = ST_IDLE;
            ST_IDLE:  if (req_valid && (req_be != '0)) state_d = ST_SETUP;
            ST_SETUP: begin
                tmr_load = 1'b1;
                tmr_val  = wr_q ? WR_LOAD : RD_LOAD;
                state_d  = wr_q ? ST_WRITE : ST_READ;
            end
            ST_READ: if (tmr_expired) begin
                tmr_load = 1'b1;
                tmr_val  = RRD_LOAD;
                state_d  = ST_RECOV;
            end
            ST_WRITE: if (tmr_expired) state_d = ST_WHOLD;
            ST_WHOLD: begin
                tmr_load = 1'b1;
                tmr_val  = RWR_LOAD;
                state_d  = ST_RECOV;
            end
            ST_RECOV: if (tmr_expired) state_d = ST_IDLE;
            default:  state_d = ST_PWRUP;
        endcase
    end

    // Memory-side and handshake outputs
    always_comb begin
        sel        = (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_ce1_n  = !sel;
        mem_ce2    = sel;
        mem_oe_n   = (state_q != ST_READ);
        mem_we_n   = (state_q != ST_WRITE);
        mem_lane_n = sel ? ~be_q : '1;
        dq_oe      = (state_q == ST_WRITE) || (state_q == ST_WHOLD);
        req_ready  = (state_q == ST_IDLE);
    end

    assign mem_addr = addr_q;
    assign mem_dq   = dq_oe ? wdata_q : 'z;

    // Request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    // Read response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept && (req_be == '0) && !req_write) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= '0;
            end else if ((state_q == ST_READ) && tmr_expired) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= mem_dq & lane_mask;
            end
        end
    end

    // Pin-level run-length monitors for the timing assertions
    localparam int MON_W = $clog2(MAXSEL_CYC + 2);
    logic [MON_W-1:0] sel_run, desel_run, oe_hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_run   <= '0;
            desel_run <= '0;
            oe_hi_run <= '0;
        end else begin
            sel_run   <= sel ? ((sel_run == '1) ? sel_run : sel_run + 1'b1) : '0;
            desel_run <= !sel ? ((desel_run == '1) ? desel_run : desel_run + 1'b1) : '0;
            oe_hi_run <= mem_oe_n ? ((oe_hi_run == '1) ? oe_hi_run : oe_hi_run + 1'b1) : '0;
        end
    end

    assert_select_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ce1_n == !mem_ce2))
        else $error("chip enables disagree");

    assert_lane_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce1_n && mem_ce2) |-> (mem_lane_n != '1))
        else $error("selected with both lanes off");

    assert_oe_only_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce1_n && mem_ce2))
        else $error("output enable outside a read");

    assert_lockout_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pu_done |-> (mem_ce1_n && !mem_ce2 && !req_ready))
        else $error("activity during power-up");

    assert_deselect_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce2) |-> (desel_run >= MON_W'(CD_CYC)))
        else $error("deselect gap too short");

    assert_addr_before_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce2) |-> $stable(mem_addr))
        else $error("address moved as chip selected");

    assert_addr_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ce2 && $past(mem_ce2)) |-> $stable(mem_addr))
        else $error("address moved while selected");

    assert_max_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce2 |-> (sel_run < MON_W'(MAXSEL_CYC - 1)))
        else $error("selected too long");

    assert_turnoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (oe_hi_run >= MON_W'(HZOE_CYC)))
        else $error("bus driven too soon after output enable");

endmodule

// File: tb/test_psram_ctl.sv
module test_psram_ctl;

    localparam int PER    = 8;
    localparam int T_PU   = 800;
    localparam int PU     = (T_PU + PER - 1) / PER;
    localparam int RD     = 9;   // ceil(70/8)
    localparam int WR     = 9;   // ceil(70/8)
    localparam int CD     = 2;   // ceil(15/8)
    localparam int HZOE   = 4;   // ceil(25/8)
    localparam int RECRD  = 4;
    localparam int RECWR  = 2;
    localparam int MAXSEL = 5000;

    typedef struct {
        bit          sel;
        bit          oe_n;
        bit          we_n;
        bit          ready;
        bit          rsp;
        bit          chk_addr;
        bit          chk_dq;
        bit          zm;
        logic [19:0] addr;
        logic [1:0]  lane_n;
        logic [15:0] data;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n;
    logic [1:0]  mem_lane_n;
    logic [19:0] mem_addr;
    wire  [15:0] mem_dq;

    int checks = 0;
    int fails  = 0;
    int edge_n = 0;
    bit finished = 1'b0;

    exp_t q[$];
    logic [15:0] dev_mem[int];
    logic [15:0] shadow[int];

    always #(PER/2) clk = ~clk;

    psram_ctl #(.CLK_PERIOD_NS(PER), .T_PU_NS(T_PU)) i_psram_ctl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n), .mem_addr(mem_addr),
        .mem_dq(mem_dq)
    );

    // Memory device model
    wire dev_sel = !mem_ce1_n && mem_ce2;
    wire dev_drv = dev_sel && !mem_oe_n && mem_we_n;
    wire [15:0] dev_word = dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : 16'h0000;
    assign mem_dq[7:0]  = (dev_drv && !mem_lane_n[0]) ? dev_word[7:0]  : 8'hzz;
    assign mem_dq[15:8] = (dev_drv && !mem_lane_n[1]) ? dev_word[15:8] : 8'hzz;

    always @(negedge clk) begin
        if (dev_sel && !mem_we_n) begin
            logic [15:0] w;
            w = dev_word;
            if (!mem_lane_n[0]) w[7:0]  = mem_dq[7:0];
            if (!mem_lane_n[1]) w[15:8] = mem_dq[15:8];
            dev_mem[int'(mem_addr)] = w;
        end
    end

    always @(posedge clk) if (rst_n) edge_n <= edge_n + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic exp_t idle_e(input bit rdy);
        exp_t e;
        e.sel = 0; e.oe_n = 1; e.we_n = 1; e.ready = rdy; e.rsp = 0;
        e.chk_addr = 0; e.chk_dq = 0; e.zm = 0; e.addr = '0;
        e.lane_n = 2'b11; e.data = '0;
        return e;
    endfunction

    function automatic logic [15:0] sh_rd(input logic [19:0] a);
        return shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    endfunction

    // Reference model: per-cycle expectations, compared at each falling edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            exp_t e, n;
            e = (q.size() > 0) ? q.pop_front() : idle_e(edge_n >= PU + 1);
            chk(e.zm ? "R10 select" : "R1 select", {31'd0, !mem_ce1_n && mem_ce2}, {31'd0, e.sel});
            chk("R1 ce2", {31'd0, mem_ce2}, {31'd0, e.sel});
            chk("R3 oe_n", {31'd0, mem_oe_n}, {31'd0, e.oe_n});
            chk("R3 we_n", {31'd0, mem_we_n}, {31'd0, e.we_n});
            chk(edge_n < PU + 1 ? "R4 ready" : "R11 ready", {31'd0, req_ready}, {31'd0, e.ready});
            chk("R5 rsp_valid", {31'd0, rsp_valid}, {31'd0, e.rsp});
            chk("R2 lanes", {30'd0, mem_lane_n}, {30'd0, e.lane_n});
            if (e.rsp) chk(e.zm ? "R10 rdata" : "R5 rdata", {16'd0, rsp_rdata}, {16'd0, e.data});
            if (e.chk_addr) chk("R7 addr", {12'd0, mem_addr}, {12'd0, e.addr});
            if (e.chk_dq) chk("R3 wdata", {16'd0, mem_dq}, {16'd0, e.data});

            if (req_valid && e.ready) begin
                logic [15:0] m;
                m = {{8{req_be[1]}}, {8{req_be[0]}}};
                if (req_be == 2'b00) begin
                    n = idle_e(1); n.zm = 1; n.rsp = !req_write; n.data = '0;
                    q.push_back(n);
                end else begin
                    n = idle_e(0); n.chk_addr = 1; n.addr = req_addr;
                    q.push_back(n);
                    if (!req_write) begin
                        for (int i = 0; i < RD; i++) begin
                            n = idle_e(0); n.sel = 1; n.oe_n = 0; n.lane_n = ~req_be;
                            n.chk_addr = 1; n.addr = req_addr;
                            q.push_back(n);
                        end
                        for (int i = 0; i < RECRD; i++) begin
                            n = idle_e(0);
                            if (i == 0) begin n.rsp = 1; n.data = sh_rd(req_addr) & m; end
                            q.push_back(n);
                        end
                    end else begin
                        for (int i = 0; i < WR; i++) begin
                            n = idle_e(0); n.sel = 1; n.we_n = 0; n.lane_n = ~req_be;
                            n.chk_addr = 1; n.addr = req_addr; n.chk_dq = 1; n.data = req_wdata;
                            q.push_back(n);
                        end
                        n = idle_e(0); n.chk_dq = 1; n.data = req_wdata;
                        q.push_back(n);
                        for (int i = 0; i < RECWR; i++) q.push_back(idle_e(0));
                        shadow[int'(req_addr)] = (sh_rd(req_addr) & ~m) | (req_wdata & m);
                    end
                end
            end
        end
    end

    // Pin-level gap and run-length checks
    int sel_run = 0, desel_run = 1000, oehi_run = 1000;
    bit prev_sel = 0, prev_we_n = 1;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit s;
            s = !mem_ce1_n && mem_ce2;
            if (s && !prev_sel) chk("R6 deselect gap ok", {31'd0, desel_run >= CD}, 32'd1);
            if (!mem_we_n && prev_we_n) chk("R9 turn-off gap ok", {31'd0, oehi_run >= HZOE}, 32'd1);
            if (s && sel_run + 1 >= MAXSEL) chk("R8 select run", sel_run + 1, MAXSEL - 1);
            sel_run   = s ? sel_run + 1 : 0;
            desel_run = s ? 0 : desel_run + 1;
            oehi_run  = mem_oe_n ? oehi_run + 1 : 0;
            prev_sel  = s;
            prev_we_n = mem_we_n;
        end
    end

    task automatic do_req(input bit wr, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R4: first request arrives during the power-up lockout
        do_req(1, 20'h12345, 16'hBEEF, 2'b11);
        do_req(0, 20'h12345, 16'h0000, 2'b11);
        // R2: lane-selective write and reads
        do_req(1, 20'h12345, 16'h0011, 2'b01);
        do_req(0, 20'h12345, 16'h0000, 2'b11);
        do_req(0, 20'h12345, 16'h0000, 2'b10);
        do_req(0, 20'h12345, 16'h0000, 2'b01);
        // R10: zero-mask requests
        do_req(1, 20'h12345, 16'hFFFF, 2'b00);
        do_req(0, 20'h12345, 16'h0000, 2'b00);
        do_req(0, 20'h12345, 16'h0000, 2'b11);
        // Address extremes; R9 write right after read
        do_req(1, 20'hFFFFF, 16'hA5C3, 2'b11);
        do_req(0, 20'hFFFFF, 16'h0000, 2'b11);
        do_req(1, 20'h00000, 16'h5A3C, 2'b10);
        do_req(0, 20'h00000, 16'h0000, 2'b11);
        for (int i = 0; i < 8; i++)
            do_req(1, 20'((i * 20'h1357 + 3) & 20'hFFFFF), 16'((i * 16'h1111) ^ 16'h0F0F), 2'b11);
        for (int i = 0; i < 8; i++)
            do_req(0, 20'((i * 20'h1357 + 3) & 20'hFFFFF), 16'h0000, 2'(i % 3 + 1));
        while (q.size() > 0) @(negedge clk);
        repeat (5) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule